// File: doc/BRIEF.md
# Shift, Rotate and Bitwise Logic Unit

This block is a purely combinational datapath unit. It takes two operands of equal width and a 3-bit operation code, and it returns one result of the same width. Five of the eight codes move the bits of operand A. These are logical shifts in both directions, an arithmetic right shift and rotations in both directions. The distance for these codes comes from the low bits of operand B. The other three codes combine A and B bit by bit.

The unit has no clock, reset or stored state. The result depends only on the present operands and code, so it can sit directly in an execute stage between the operand registers and the write-back mux. The width is a parameter and must be a power of two. The default is 32 bits, which gives a 5-bit distance field.

Top module: `shrot_alu`

## Requirements
- R1: Code 3'b000 gives A shifted left by the distance, with zeros entering at bit 0.
- R2: Code 3'b001 gives A shifted right by the distance, with zeros entering at the top bit.
- R3: Code 3'b010 gives A shifted right by the distance, with every vacated top bit equal to bit WIDTH-1 of A. A negative A therefore stays negative.
- R4: Code 3'b011 gives A rotated left by the distance. Bits leaving the top re-enter at bit 0.
- R5: Code 3'b100 gives A rotated right by the distance. Bits leaving bit 0 re-enter at the top.
- R6: Code 3'b101 gives the bitwise AND of A and B.
- R7: Code 3'b110 gives the bitwise inclusive OR of A and B.
- R8: Code 3'b111 gives the bitwise exclusive OR of A and B.
- R9: The distance for codes 000 to 100 is B[log2(WIDTH)-1:0], which is B[4:0] at the default width. The bits of B above that field do not change the result.
- R10: A distance of 0 returns A unchanged for every shift and rotate code.
- R11: The result follows any change of the operands or the code without a clock edge, and it holds no state from earlier inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | WIDTH | Operand A: the value that is shifted or rotated, and the first bitwise operand |
| opb_i | input | WIDTH | Operand B: the distance in its low log2(WIDTH) bits, and the second bitwise operand |
| op_i | input | 3 | Operation code |
| res_o | output | WIDTH | Result |

## Verification
The bench builds two copies of the unit.

The first copy has WIDTH set to 8. At that width the bench sweeps every value of A against every 3-bit distance and every code. This covers every fill pattern, every wrap-around point and every carry of the sign bit across all stage combinations of the shifter.

The second copy has the default WIDTH of 32. At that width the bench applies directed distances of 0, 1 and 31, a negative A for the arithmetic shift, B values with junk above the distance field, and random operands for every code.

// File: rtl/shrot_alu_pkg.sv
package shrot_alu_pkg;

    // Operation codes; the numeric values are part of the interface.
    typedef enum logic [2:0] {
        OP_SLL = 3'b000,
        OP_SRL = 3'b001,
        OP_SRA = 3'b010,
        OP_ROL = 3'b011,
        OP_ROR = 3'b100,
        OP_AND = 3'b101,
        OP_OR  = 3'b110,
        OP_XOR = 3'b111
    } alu_op_e;

    // Steering for the shared right-moving barrel.
    typedef struct packed {
        logic mirror;   // reverse bit order before and after the barrel
        logic wrap;     // vacated bits come from the bits shifted out
        logic signfill; // vacated bits copy the operand's top bit
        logic bitwise;  // result comes from the bitwise unit
    } alu_ctl_t;

endpackage

// File: rtl/shrot_alu_decode.sv
module shrot_alu_decode
    import shrot_alu_pkg::*;
(
    input  logic [2:0] op_i,
    output alu_ctl_t   ctl_o
);
    alu_ctl_t ctl_d;

    always_comb begin
        ctl_d = '0;
        unique case (alu_op_e'(op_i))
            OP_SLL: ctl_d.mirror   = 1'b1;
            OP_SRL: ctl_d          = '0;
            OP_SRA: ctl_d.signfill = 1'b1;
            OP_ROL: begin
                ctl_d.mirror = 1'b1;
                ctl_d.wrap   = 1'b1;
            end
            OP_ROR: ctl_d.wrap     = 1'b1;
            default: ctl_d.bitwise = 1'b1;
        endcase
    end

    assign ctl_o = ctl_d;

    always_comb begin
        if (!$isunknown(op_i)) begin
            // R3
            fill_excl_chk: assert (!(ctl_d.wrap && ctl_d.signfill));
        end
    end
endmodule

// File: rtl/shrot_alu_mirror.sv
module shrot_alu_mirror #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             en_i,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] dout_o
);
    logic [WIDTH-1:0] rev_d;

    for (genvar i = 0; i < WIDTH; i++) begin : g_rev
        assign rev_d[i] = din_i[WIDTH-1-i];
    end

    assign dout_o = en_i ? rev_d : din_i;
endmodule

// File: rtl/shrot_alu_barrel.sv
module shrot_alu_barrel #(
    parameter int unsigned WIDTH = 32,
    localparam int unsigned AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] din_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic             wrap_i,
    input  logic             fill_i,
    output logic [WIDTH-1:0] dout_o
);
    // Stage k moves the word right by 2**k when amt_i[k] is set.
    logic [AMT_W:0][WIDTH-1:0] stg_d;

    assign stg_d[0] = din_i;

    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        localparam int unsigned STEP = 1 << k;
        logic [STEP-1:0] enter_d;
        assign enter_d = wrap_i ? stg_d[k][STEP-1:0] : {STEP{fill_i}};
        assign stg_d[k+1] = amt_i[k] ? {enter_d, stg_d[k][WIDTH-1:STEP]}
                                     : stg_d[k];
    end

    assign dout_o = stg_d[AMT_W];

    always_comb begin
        if (!$isunknown({din_i, amt_i, wrap_i})) begin
            // R5
            wrap_bits_chk: assert (!wrap_i ||
                ($countones(dout_o) == $countones(din_i)));
        end
    end
endmodule

// File: rtl/shrot_alu_bitwise.sv
module shrot_alu_bitwise
    import shrot_alu_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [2:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] y_o
);
    logic [WIDTH-1:0] y_d;

    always_comb begin
        unique case (alu_op_e'(op_i))
            OP_AND:  y_d = a_i & b_i;
            OP_OR:   y_d = a_i | b_i;
            OP_XOR:  y_d = a_i ^ b_i;
            default: y_d = '0;
        endcase
    end

    assign y_o = y_d;
endmodule

// File: rtl/shrot_alu.sv
module shrot_alu
    import shrot_alu_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic [2:0]       op_i,
    output logic [WIDTH-1:0] res_o
);
    localparam int unsigned AMT_W = $clog2(WIDTH);

    alu_ctl_t         ctl_d;
    logic [AMT_W-1:0] amt_d;
    logic             fill_d;
    logic [WIDTH-1:0] pre_d;
    logic [WIDTH-1:0] moved_d;
    logic [WIDTH-1:0] post_d;
    logic [WIDTH-1:0] logic_d;
    logic [WIDTH-1:0] res_d;

    shrot_alu_decode u_dec (
        .op_i  (op_i),
        .ctl_o (ctl_d)
    );

    assign amt_d  = opb_i[AMT_W-1:0];
    assign fill_d = ctl_d.signfill & opa_i[WIDTH-1];

    shrot_alu_mirror #(.WIDTH(WIDTH)) u_mir_in (
        .en_i   (ctl_d.mirror),
        .din_i  (opa_i),
        .dout_o (pre_d)
    );

    shrot_alu_barrel #(.WIDTH(WIDTH)) u_bar (
        .din_i  (pre_d),
        .amt_i  (amt_d),
        .wrap_i (ctl_d.wrap),
        .fill_i (fill_d),
        .dout_o (moved_d)
    );

    shrot_alu_mirror #(.WIDTH(WIDTH)) u_mir_out (
        .en_i   (ctl_d.mirror),
        .din_i  (moved_d),
        .dout_o (post_d)
    );

    shrot_alu_bitwise #(.WIDTH(WIDTH)) u_bit (
        .op_i (op_i),
        .a_i  (opa_i),
        .b_i  (opb_i),
        .y_o  (logic_d)
    );

    always_comb begin
        res_d = ctl_d.bitwise ? logic_d : post_d;
    end

    assign res_o = res_d;

    always_comb begin
        if (!$isunknown({opa_i, opb_i, op_i})) begin
            // R10
            zero_dist_chk: assert (ctl_d.bitwise || (amt_d != '0) ||
                                   (res_o == opa_i));
            // R3
            sign_keep_chk: assert ((op_i != 3'b010) ||
                                   (res_o[WIDTH-1] == opa_i[WIDTH-1]));
            // R6
            and_subset_chk: assert ((op_i != 3'b101) ||
                                    ((res_o & ~opa_i) == '0));
            // R2
            srl_loss_chk: assert ((op_i != 3'b001) ||
                ($countones(res_o) <= $countones(opa_i)));
            // R4
            rol_bits_chk: assert ((op_i != 3'b011) ||
                ($countones(res_o) == $countones(opa_i)));
        end
    end
endmodule

// File: tb/sim_shrot_alu.sv
`timescale 1ns/1ps
module sim_shrot_alu;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [31:0] a32, b32, r32;
    logic [2:0]  op32;
    logic [7:0]  a8, b8, r8;
    logic [2:0]  op8;
    int checks = 0;
    int errors = 0;

    shrot_alu #(.WIDTH(32)) u0 (.opa_i(a32), .opb_i(b32), .op_i(op32), .res_o(r32));
    shrot_alu #(.WIDTH(8))  u1 (.opa_i(a8),  .opb_i(b8),  .op_i(op8),  .res_o(r8));

    function automatic logic [31:0] model(input int w, input logic [31:0] a,
                                          input logic [31:0] b, input logic [2:0] op);
        logic [63:0] m, x, y;
        int s;
        m = (64'd1 << w) - 64'd1;
        x = {32'd0, a} & m;
        y = {32'd0, b} & m;
        s = int'(b) & (w - 1);
        case (op)
            3'd0: model = 32'((x << s) & m);
            3'd1: model = 32'(x >> s);
            3'd2: model = x[w-1] ? 32'((x >> s) | (m & ~(m >> s))) : 32'(x >> s);
            3'd3: model = 32'(((x << s) | (x >> (w - s))) & m);
            3'd4: model = 32'(((x >> s) | (x << (w - s))) & m);
            3'd5: model = 32'(x & y);
            3'd6: model = 32'(x | y);
            default: model = 32'(x ^ y);
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0: tag_of = "R1";
            3'd1: tag_of = "R2";
            3'd2: tag_of = "R3";
            3'd3: tag_of = "R4";
            3'd4: tag_of = "R5";
            3'd5: tag_of = "R6";
            3'd6: tag_of = "R7";
            default: tag_of = "R8";
        endcase
    endfunction

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run32(input logic [31:0] a, input logic [31:0] b,
                         input logic [2:0] op, input string tag);
        @(posedge clk);
        #2;
        a32 = a; b32 = b; op32 = op;
        #3;
        cmp(tag, r32, model(32, a, b, op));
    endtask

    initial begin
        #20_000_000;
        checks++;
        errors++;
        $display("FAIL R11 watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        a32 = '0; b32 = '0; op32 = '0;
        a8 = '0; b8 = '0; op8 = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #3;
        cmp("R11 idle", r32, 32'd0);

        // Distance 0, 1 and 31 on every shift and rotate code
        for (int op = 0; op < 5; op++) begin
            run32(32'h8000_00F1, 32'd0, 3'(op), "R10");
            run32(32'h8000_00F1, 32'd1, 3'(op), tag_of(3'(op)));
            run32(32'h8000_00F1, 32'd31, 3'(op), tag_of(3'(op)));
            run32(32'h4C3A_96E5, 32'd31, 3'(op), tag_of(3'(op)));
        end
        // Negative and positive A through the arithmetic shift
        run32(32'hF000_0000, 32'd4, 3'd2, "R3");
        run32(32'h8000_0000, 32'd31, 3'd2, "R3");
        run32(32'h7FFF_FFFF, 32'd30, 3'd2, "R3");
        // Bits of B above the distance field have no effect
        for (int op = 0; op < 5; op++) begin
            run32(32'h1234_5678, 32'hFFFF_FFE3, 3'(op), "R9");
            cmp("R9 high-B", r32, model(32, 32'h1234_5678, 32'd3, 3'(op)));
        end
        // Result changes between clock edges with no clock involved
        @(negedge clk);
        a32 = 32'hA5A5_0000; b32 = 32'h00FF_FF00; op32 = 3'd7;
        #1;
        cmp("R11", r32, 32'hA55A_FF00);
        op32 = 3'd5;
        #1;
        cmp("R11", r32, 32'h00A5_0000);
        // Random operands at full width
        for (int op = 0; op < 8; op++) begin
            for (int n = 0; n < 300; n++) begin
                run32($urandom, $urandom, 3'(op), tag_of(3'(op)));
            end
        end
        // Exhaustive sweep at width 8
        for (int op = 0; op < 8; op++) begin
            for (int s = 0; s < 8; s++) begin
                for (int a = 0; a < 256; a++) begin
                    @(posedge clk);
                    #2;
                    a8 = 8'(a);
                    b8 = 8'((a * 37 + 11) & 8'hF8) | 8'(s);
                    op8 = 3'(op);
                    #3;
                    cmp(tag_of(3'(op)), {24'd0, r8}, model(8, {24'd0, a8}, {24'd0, b8}, op8));
                end
            end
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule